// File: doc/BRIEF.md
# SPI Hold Pause Gate

This block sits between the pins of an SPI slave and its shift logic, and adds a pause driven by an active-low hold input. It runs on a fast system clock. All pin inputs are assumed to be already synchronised to that clock. The block turns the serial clock into one-cycle rise and fall strobes for the slave core.

While a pause is in force, the block suppresses those strobes. It freezes the serial data seen by the core and releases the serial output line. No shift state is cleared, so the transfer carries on from the bit where it stopped. A pause can start or end only in a cycle where the serial clock is sampled low. A hold edge seen while the clock is high therefore waits until the clock next falls.

A hold request counts only once the device is selected and at least one serial clock rising edge has reached the core. Deselecting the device ends any pause along with the transfer.

Top module: `spi_hold_gate`

## Requirements
- R1: In reset, and in the first cycle after it with chip select high, `hold_active`, `rise_en`, `fall_en` and `so_oe` are all 0.
- R2: With `cs_n` low and no pause, `rise_en` is 1 in exactly the cycle where `sck` is sampled 1 after having been sampled 0 in the previous cycle.
- R3: With `cs_n` low and no pause, `fall_en` is 1 in exactly the cycle where `sck` is sampled 0 after having been sampled 1 in the previous cycle.
- R4: While `cs_n` is 1, `rise_en`, `fall_en` and `so_oe` are 0.
- R5: If `hold_n` is sampled 0 in a cycle where `sck` is 0, `cs_n` is 0 and a rising strobe has already been issued in this selection, `hold_active` is 1 from the next cycle.
- R6: A hold level sampled while `sck` is 1 does not change `hold_active`. It takes effect in the cycle after `sck` is next sampled 0.
- R7: A low `hold_n` before the first rising strobe of a selection does not start a pause.
- R8: While `hold_active` is 1, no `rise_en` or `fall_en` strobe is issued, and `si_core` holds the `si` value sampled in the last cycle before the pause began.
- R9: `so_oe` equals `core_so_en` when `cs_n` is 0 and `hold_active` is 0; otherwise it is 0. `so_data` always equals `core_so`.
- R10: A pause ends in the cycle after `hold_n` is sampled 1 together with `sck` 0. Strobes resume from the next clock edge, with no edge lost or repeated.
- R11: `cs_n` sampled 1 clears `hold_active` from the next cycle and forgets that a transfer had started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, synchronised |
| sck | input | 1 | Serial clock level, synchronised |
| hold_n | input | 1 | Pause request, active low, synchronised |
| si | input | 1 | Serial data in |
| core_so | input | 1 | Serial data out from the slave core |
| core_so_en | input | 1 | Output enable from the slave core |
| rise_en | output | 1 | One-cycle strobe for a serial clock rising edge |
| fall_en | output | 1 | One-cycle strobe for a serial clock falling edge |
| si_core | output | 1 | Serial data toward the core, frozen during a pause |
| hold_active | output | 1 | Pause in force |
| so_data | output | 1 | Value for the serial output pad |
| so_oe | output | 1 | Enable for the serial output pad, 0 means high impedance |

## Verification
The strobes, `so_oe`, `so_data` and `si_core` are combinational from the current inputs and the registered state, so they are due in the same cycle as the stimulus. `hold_active` and the frozen data change one cycle after the qualifying sample. The bench drives inputs one nanosecond after the rising clock edge and reads every output at the falling edge. A behavioural model, advanced at the same point, predicts each output, and the bench compares all outputs in every cycle. Directed sequences place hold edges while the serial clock is high, before the first edge, and during deselection, which exercises each timing case.

// File: rtl/spi_hold_pkg.sv
// Package: shared types for the SPI hold pause gate.
// Assumes nothing beyond being compiled first.
package spi_hold_pkg;

    // Pair of serial clock edge strobes, one system clock wide.
    typedef struct packed {
        logic rise;
        logic fall;
    } sck_edge_t;

    // Sampled level of the serial clock after reset.
    localparam logic SCK_RESET_LEVEL = 1'b0;

endpackage

// File: rtl/hold_edge_detect.sv
// Module: hold_edge_detect
// Keeps the serial clock level from the previous system clock cycle and
// reports raw rise and fall edges of the present sample.
// Assumes sck is already synchronised to clk.
module hold_edge_detect
    import spi_hold_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sck,
    output sck_edge_t edge_raw
);

    logic sck_prev;

    // Remember the serial clock level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_prev <= SCK_RESET_LEVEL;
        else        sck_prev <= sck;
    end

    // Compare the present sample with the stored level.
    always_comb begin
        edge_raw.rise = sck & ~sck_prev;
        edge_raw.fall = ~sck & sck_prev;
    end

endmodule

// File: rtl/hold_qualifier.sv
// Module: hold_qualifier
// Tracks whether a transfer has started in the present selection, and
// accepts a change of the pause state only in cycles where sck is low.
// Assumes all inputs are synchronised to clk.
module hold_qualifier (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic hold_n,
    input  logic rise_pass,
    output logic paused
);

    logic started;

    // Note that the first rising strobe of this selection has reached the core.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) started <= 1'b0;
        else if (rise_pass) started <= 1'b1;
    end

    // Follow the hold request only while sck is low and a transfer is underway.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n)      paused <= 1'b0;
        else if (!sck && started) paused <= ~hold_n;
    end

endmodule

// File: rtl/hold_output_gate.sv
// Module: hold_output_gate
// Masks edge strobes, freezes serial data toward the core and releases
// the serial output while deselected or paused.
// Assumes the pause flag is a registered signal.
module hold_output_gate
    import spi_hold_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cs_n,
    input  logic      paused,
    input  sck_edge_t edge_raw,
    input  logic      si,
    input  logic      core_so,
    input  logic      core_so_en,
    output sck_edge_t edge_gated,
    output logic      si_core,
    output logic      so_data,
    output logic      so_oe
);

    logic si_last;
    logic pass;

    // Strobes and output drive are allowed only when selected and running.
    always_comb begin
        pass            = ~cs_n & ~paused;
        edge_gated.rise = edge_raw.rise & pass;
        edge_gated.fall = edge_raw.fall & pass;
        so_oe           = core_so_en & pass;
        so_data         = core_so;
        si_core         = paused ? si_last : si;
    end

    // Capture serial data every cycle until a pause begins.
    always_ff @(posedge clk) begin
        if (!rst_n)       si_last <= 1'b0;
        else if (!paused) si_last <= si;
    end

endmodule

// File: rtl/spi_hold_gate.sv
// Module: spi_hold_gate (top)
// Pause gate between SPI pins and a slave core: converts sck into edge
// strobes, and on a qualified active-low hold freezes the core's view
// of the bus and tristates the serial output without resetting anything.
// Assumes pin inputs are synchronised to clk; no glitch filtering.
module spi_hold_gate
    import spi_hold_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic hold_n,
    input  logic si,
    input  logic core_so,
    input  logic core_so_en,
    output logic rise_en,
    output logic fall_en,
    output logic si_core,
    output logic hold_active,
    output logic so_data,
    output logic so_oe
);

    sck_edge_t edge_raw;
    sck_edge_t edge_gated;
    logic      paused;

    hold_edge_detect u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (sck),
        .edge_raw (edge_raw)
    );

    hold_qualifier u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sck       (sck),
        .hold_n    (hold_n),
        .rise_pass (edge_gated.rise),
        .paused    (paused)
    );

    hold_output_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .paused     (paused),
        .edge_raw   (edge_raw),
        .si         (si),
        .core_so    (core_so),
        .core_so_en (core_so_en),
        .edge_gated (edge_gated),
        .si_core    (si_core),
        .so_data    (so_data),
        .so_oe      (so_oe)
    );

    // Drive the top-level outputs from the submodules.
    always_comb begin
        rise_en     = edge_gated.rise;
        fall_en     = edge_gated.fall;
        hold_active = paused;
    end

endmodule

// File: rtl/spi_hold_gate_chk.sv
// Module: spi_hold_gate_chk
// Checker for the pause gate's port-level properties, bound to the top.
module spi_hold_gate_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sck,
    input logic si_core,
    input logic core_so_en,
    input logic rise_en,
    input logic fall_en,
    input logic hold_active,
    input logic so_oe
);

    // R8
    no_strobe_paused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_active |-> (!rise_en && !fall_en));

    // R8
    si_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_active && $past(hold_active)) |-> $stable(si_core));

    // R4
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (!rise_en && !fall_en && !so_oe));

    // R11
    cs_clears_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !hold_active);

    // R6
    hold_moves_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_active != $past(hold_active) && !$past(cs_n)) |-> !$past(sck));

    // R9
    so_needs_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
        so_oe |-> core_so_en);

endmodule

bind spi_hold_gate spi_hold_gate_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .sck         (sck),
    .si_core     (si_core),
    .core_so_en  (core_so_en),
    .rise_en     (rise_en),
    .fall_en     (fall_en),
    .hold_active (hold_active),
    .so_oe       (so_oe)
);

// File: tb/spi_hold_gate_bench.sv
// Bench: behavioural reference model compared on every clock.
module spi_hold_gate_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, hold_n = 1'b1, si = 1'b0;
    logic core_so = 1'b0, core_so_en = 1'b0;
    logic rise_en, fall_en, si_core, hold_active, so_data, so_oe;

    int checks = 0;
    int errors = 0;
    int rises_seen = 0;

    // model state
    bit m_prev = 0, m_hold = 0, m_started = 0, m_si_last = 0;

    always #2 clk = ~clk;

    spi_hold_gate u_spi_hold_gate (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .hold_n(hold_n),
        .si(si), .core_so(core_so), .core_so_en(core_so_en),
        .rise_en(rise_en), .fall_en(fall_en), .si_core(si_core),
        .hold_active(hold_active), .so_data(so_data), .so_oe(so_oe)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Apply inputs, compare all outputs at the falling edge, advance the model.
    task automatic step(input bit c, input bit k, input bit h, input bit d, input bit oe);
        bit e_rise, e_fall, pass;
        cs_n = c; sck = k; hold_n = h; si = d; core_so_en = oe; core_so = d ^ k;
        @(negedge clk);
        pass   = !c && !m_hold;
        e_rise = k && !m_prev && pass;
        e_fall = !k && m_prev && pass;
        chk("R2", "rise_en", rise_en, e_rise);
        chk("R3", "fall_en", fall_en, e_fall);
        chk("R5", "hold_active", hold_active, m_hold);
        chk("R9", "so_oe", so_oe, oe && pass);
        chk("R9", "so_data", so_data, d ^ k);
        chk("R8", "si_core", si_core, m_hold ? m_si_last : d);
        if (rise_en) rises_seen++;
        if (!rst_n) begin
            m_prev = 0; m_hold = 0; m_started = 0; m_si_last = 0;
        end else begin
            if (!m_hold) m_si_last = d;
            m_prev = k;
            if (c) begin
                m_hold = 0; m_started = 0;
            end else begin
                if (!k && m_started) m_hold = !h;
                if (e_rise) m_started = 1;
            end
        end
        @(posedge clk); #1;
    endtask

    // One serial clock bit: two system cycles low, two high.
    task automatic sbit(input bit h, input bit d);
        step(0, 0, h, d, 1); step(0, 0, h, d, 1);
        step(0, 1, h, d, 1); step(0, 1, h, d, 1);
    endtask

    initial begin
        #(200000 * 4);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1;
        // R1: reset state
        for (int i = 0; i < 3; i++) step(1, 0, 1, 0, 0);
        rst_n = 1;
        step(1, 0, 1, 0, 1);
        chk("R1", "hold after reset", hold_active, 1'b0);
        chk("R4", "so_oe deselected", so_oe, 1'b0);

        // R7: hold low before first edge is ignored
        step(0, 0, 0, 1, 1); step(0, 0, 0, 1, 1);
        chk("R7", "no early pause", hold_active, 1'b0);
        step(0, 0, 1, 1, 1);

        // R2 R3: a few bits with a data pattern
        for (int i = 0; i < 4; i++) sbit(1, i[0]);
        step(0, 0, 1, 1, 1);

        // R5: enter pause with sck low, then toggle pins
        step(0, 0, 0, 1, 1);
        chk("R5", "pause entered", hold_active, 1'b1);
        for (int i = 0; i < 3; i++) begin
            step(0, 1, 0, 0, 1); step(0, 0, 0, 1, 1);
        end
        chk("R8", "still paused", hold_active, 1'b1);

        // R6: release while sck high is deferred
        step(0, 1, 1, 0, 1); step(0, 1, 1, 0, 1);
        chk("R6", "release deferred", hold_active, 1'b1);
        step(0, 0, 1, 0, 1);
        step(0, 0, 1, 0, 1);
        chk("R10", "pause ended", hold_active, 1'b0);
        rises_seen = 0;
        for (int i = 0; i < 3; i++) sbit(1, ~i[0]);
        chk("R10", "three edges after resume", rises_seen == 3, 1'b1);

        // R6: hold falls while sck high, takes effect once sck low
        step(0, 1, 0, 1, 1);
        step(0, 1, 0, 1, 1);
        chk("R6", "entry deferred", hold_active, 1'b0);
        step(0, 0, 0, 1, 1);
        step(0, 0, 0, 0, 1);
        chk("R6", "entry after sck low", hold_active, 1'b1);

        // R11: deselect during pause
        step(1, 0, 0, 0, 1);
        step(1, 0, 0, 0, 1);
        chk("R11", "deselect clears", hold_active, 1'b0);
        step(0, 0, 0, 1, 1); step(0, 0, 0, 1, 1);
        chk("R11", "restart forgotten", hold_active, 1'b0);
        for (int i = 0; i < 2; i++) sbit(1, i[0]);
        step(1, 0, 1, 0, 0);
        step(1, 0, 1, 0, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule